// File: doc/BRIEF.md
# Integer Result Flag and Condition Unit

This unit sits behind an integer ALU and turns each finished operation into updates of a fixed-point exception register and a four-bit record condition field. The decode stage supplies the raw operands, the ALU result and a set of per-operation controls. Those controls can invert the first operand, add an immediate to the operand set, and enable carry update, overflow update and condition recording on their own. A two-bit mask lets an operation that computes its own carry bits write them directly, in place of the inferred carry.

Carry is inferred without a carry chain. An operation sets the carry flag when any operand in the set, read as an unsigned number, is larger than the result. The same test on the low half of every word gives the half-width carry. Overflow uses the sign bits of the first two operands and of the result, at full width and at half width. A sticky summary bit collects every overflow it sees.

The flags and the condition field are registers. They change only on a clock edge where the valid strobe is high, and they read as zero after reset.

Top module: `int_flag_unit`

## Requirements
- R1: After reset, ca_o, ca32_o, ov_o, ov32_o, so_o and cond_o all read 0.
- R2: The flags and cond_o change only on a rising clock edge where valid_i is high, and the new values are visible after that edge. With valid_i low they hold, whatever the other inputs do.
- R3: When inv_a_i is high, op_a_i is bitwise inverted before it enters the carry and overflow evaluation.
- R4: The operand set always holds operand A. It holds op_b_i when b_vld_i is high and imm_i when imm_vld_i is high.
- R5: With carry_en_i high and own_mask_i[0] low, ca_o becomes 1 when any operand in the set is unsigned-greater than result_i over the full 64 bits, and 0 otherwise.
- R6: With carry_en_i high and own_mask_i[1] low, ca32_o follows the same rule applied to bits 31:0 of the operands and of the result.
- R7: With carry_en_i high, own_mask_i[0] high makes ca_o take own_ca_i, and own_mask_i[1] high makes ca32_o take own_ca32_i. With carry_en_i low the mask and the own carry inputs have no effect.
- R8: With ovf_en_i high, the first operand is A and the second is op_b_i when b_vld_i is high, otherwise imm_i. ov_o becomes 1 when bit 63 of both is equal and bit 63 of result_i differs from it, and 0 otherwise. If neither B nor the immediate is present, ov_o, ov32_o and so_o hold.
- R9: ov32_o follows the R8 rule on bit 31.
- R10: When overflow is updated, so_o becomes its old value ORed with the new ov_o. Only reset clears so_o.
- R11: With rec_en_i high, cond_o is {negative, positive, zero, summary} from bit 3 down to bit 0. The first three come from result_i read as a signed 64-bit number. The summary bit is so_o as updated by the same operation.
- R12: carry_en_i, ovf_en_i and rec_en_i act independently. A group whose enable is low holds its registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe; registers update only when high |
| inv_a_i | input | 1 | Invert operand A before evaluation |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| b_vld_i | input | 1 | Operand B is part of the operand set |
| imm_i | input | 64 | Immediate operand |
| imm_vld_i | input | 1 | Immediate is part of the operand set |
| result_i | input | 64 | ALU result |
| carry_en_i | input | 1 | Enable carry flag update |
| ovf_en_i | input | 1 | Enable overflow and summary update |
| rec_en_i | input | 1 | Enable condition field recording |
| own_mask_i | input | 2 | Bit 0: own carry replaces inferred carry; bit 1: same for half-width carry |
| own_ca_i | input | 1 | Carry value supplied by the operation |
| own_ca32_i | input | 1 | Half-width carry value supplied by the operation |
| ca_o | output | 1 | Carry flag |
| ca32_o | output | 1 | Half-width carry flag |
| ov_o | output | 1 | Overflow flag |
| ov32_o | output | 1 | Half-width overflow flag |
| so_o | output | 1 | Sticky summary overflow |
| cond_o | output | 4 | Recorded condition field {neg, pos, zero, summary} |

## Verification
The properties assume that valid_i, the three enables and own_mask_i carry known values on every clock edge after reset. They also assume that own_ca_i and own_ca32_i are known whenever carry is enabled with the matching mask bit set. The stimulus holds every input at a defined value from time zero and changes inputs only on the falling edge. Each operation is a one-cycle valid pulse with idle cycles between, so every property sees clean, stable antecedents. Reset is applied again in the middle of the run, so that the sticky summary bit starts from zero before the record case that depends on it.

// File: rtl/int_flag_pkg.sv
package int_flag_pkg;

    // operand slots in the evaluation set
    localparam int IFU_NUM_OPS = 3;
    localparam int IFU_OP_A    = 0;
    localparam int IFU_OP_B    = 1;
    localparam int IFU_OP_IMM  = 2;

    // width-slice indices: full word first, half word second
    localparam int IFU_NUM_SLICES = 2;
    localparam int IFU_SL_FULL    = 0;
    localparam int IFU_SL_HALF    = 1;

    localparam int IFU_COND_W = 4;

    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } ifu_flags_t;

endpackage

// File: rtl/ifu_operand_prep.sv
module ifu_operand_prep
    import int_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                                  inv_a_i,
    input  logic [DATA_W-1:0]                     op_a_i,
    input  logic [DATA_W-1:0]                     op_b_i,
    input  logic                                  b_vld_i,
    input  logic [DATA_W-1:0]                     imm_i,
    input  logic                                  imm_vld_i,
    output logic [IFU_NUM_OPS-1:0][DATA_W-1:0]    ops_o,
    output logic [IFU_NUM_OPS-1:0]                ops_vld_o
);

    // operand A is always in the set, optionally inverted
    always_comb begin
        ops_o[IFU_OP_A]       = inv_a_i ? ~op_a_i : op_a_i;
        ops_o[IFU_OP_B]       = op_b_i;
        ops_o[IFU_OP_IMM]     = imm_i;
        ops_vld_o[IFU_OP_A]   = 1'b1;
        ops_vld_o[IFU_OP_B]   = b_vld_i;
        ops_vld_o[IFU_OP_IMM] = imm_vld_i;
    end

endmodule

// File: rtl/ifu_width_slice.sv
module ifu_width_slice
    import int_flag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [IFU_NUM_OPS-1:0][W-1:0] ops_i,
    input  logic [IFU_NUM_OPS-1:0]        ops_vld_i,
    input  logic [W-1:0]                  res_i,
    output logic                          carry_o,
    output logic                          ovf_o
);

    localparam int SIGN = W - 1;

    logic [IFU_NUM_OPS-1:0] gt_res;
    logic [W-1:0]           second;

    // one unsigned magnitude comparator per operand slot
    for (genvar g = 0; g < IFU_NUM_OPS; g++) begin : g_cmp
        assign gt_res[g] = ops_vld_i[g] && (ops_i[g] > res_i);
    end

    assign carry_o = |gt_res;

    // second operand: B when present, else the immediate
    assign second = ops_vld_i[IFU_OP_B] ? ops_i[IFU_OP_B] : ops_i[IFU_OP_IMM];

    assign ovf_o = (ops_i[IFU_OP_A][SIGN] == second[SIGN]) &&
                   (res_i[SIGN] != ops_i[IFU_OP_A][SIGN]);

endmodule

// File: rtl/ifu_cond_eval.sv
module ifu_cond_eval
    import int_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]     res_i,
    input  logic                  so_i,
    output logic [IFU_COND_W-1:0] cond_o
);

    logic is_neg;
    logic is_zero;
    logic is_pos;

    assign is_neg  = res_i[DATA_W-1];
    assign is_zero = (res_i == '0);
    assign is_pos  = !is_neg && !is_zero;

    assign cond_o = {is_neg, is_pos, is_zero, so_i};

endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit
    import int_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  inv_a_i,
    input  logic [DATA_W-1:0]     op_a_i,
    input  logic [DATA_W-1:0]     op_b_i,
    input  logic                  b_vld_i,
    input  logic [DATA_W-1:0]     imm_i,
    input  logic                  imm_vld_i,
    input  logic [DATA_W-1:0]     result_i,
    input  logic                  carry_en_i,
    input  logic                  ovf_en_i,
    input  logic                  rec_en_i,
    input  logic [1:0]            own_mask_i,
    input  logic                  own_ca_i,
    input  logic                  own_ca32_i,
    output logic                  ca_o,
    output logic                  ca32_o,
    output logic                  ov_o,
    output logic                  ov32_o,
    output logic                  so_o,
    output logic [IFU_COND_W-1:0] cond_o
);

    logic [IFU_NUM_OPS-1:0][DATA_W-1:0] ops;
    logic [IFU_NUM_OPS-1:0]             ops_vld;
    logic [IFU_NUM_SLICES-1:0]          carry_w;
    logic [IFU_NUM_SLICES-1:0]          ovf_w;
    logic                               pair_ok;

    ifu_flags_t            flags_q, flags_d;
    logic [IFU_COND_W-1:0] cond_q, cond_d, cond_new;

    ifu_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .inv_a_i   (inv_a_i),
        .op_a_i    (op_a_i),
        .op_b_i    (op_b_i),
        .b_vld_i   (b_vld_i),
        .imm_i     (imm_i),
        .imm_vld_i (imm_vld_i),
        .ops_o     (ops),
        .ops_vld_o (ops_vld)
    );

    assign pair_ok = ops_vld[IFU_OP_B] | ops_vld[IFU_OP_IMM];

    // full-width and half-width evaluation slices
    for (genvar s = 0; s < IFU_NUM_SLICES; s++) begin : g_slice
        localparam int W = (s == IFU_SL_FULL) ? DATA_W : HALF_W;
        logic [IFU_NUM_OPS-1:0][W-1:0] ops_s;

        always_comb begin
            for (int i = 0; i < IFU_NUM_OPS; i++) begin
                ops_s[i] = ops[i][W-1:0];
            end
        end

        ifu_width_slice #(.W(W)) u_slice (
            .ops_i     (ops_s),
            .ops_vld_i (ops_vld),
            .res_i     (result_i[W-1:0]),
            .carry_o   (carry_w[s]),
            .ovf_o     (ovf_w[s])
        );
    end

    // flag next-state
    always_comb begin
        flags_d = flags_q;
        if (valid_i) begin
            if (carry_en_i) begin
                flags_d.ca   = own_mask_i[0] ? own_ca_i   : carry_w[IFU_SL_FULL];
                flags_d.ca32 = own_mask_i[1] ? own_ca32_i : carry_w[IFU_SL_HALF];
            end
            if (ovf_en_i && pair_ok) begin
                flags_d.ov   = ovf_w[IFU_SL_FULL];
                flags_d.ov32 = ovf_w[IFU_SL_HALF];
                flags_d.so   = flags_q.so | ovf_w[IFU_SL_FULL];
            end
        end
    end

    // condition field sees the summary bit of this same operation
    ifu_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .res_i  (result_i),
        .so_i   (flags_d.so),
        .cond_o (cond_new)
    );

    always_comb begin
        cond_d = cond_q;
        if (valid_i && rec_en_i) begin
            cond_d = cond_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            cond_q  <= '0;
        end else begin
            flags_q <= flags_d;
            cond_q  <= cond_d;
        end
    end

    assign ca_o   = flags_q.ca;
    assign ca32_o = flags_q.ca32;
    assign ov_o   = flags_q.ov;
    assign ov32_o = flags_q.ov32;
    assign so_o   = flags_q.so;
    assign cond_o = cond_q;

endmodule

// File: rtl/int_flag_unit_chk.sv
module int_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic       carry_en_i,
    input logic       ovf_en_i,
    input logic       rec_en_i,
    input logic [1:0] own_mask_i,
    input logic       own_ca_i,
    input logic       own_ca32_i,
    input logic       ca_o,
    input logic       ca32_o,
    input logic       ov_o,
    input logic       ov32_o,
    input logic       so_o,
    input logic [3:0] cond_o
);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cond_o}));

    p_own_ca_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && carry_en_i && own_mask_i[0]) |=> (ca_o == $past(own_ca_i)));

    p_own_ca32_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && carry_en_i && own_mask_i[1]) |=> (ca32_o == $past(own_ca32_i)));

    p_so_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |=> so_o);

    p_ov_sets_so_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ovf_en_i) |=> (!ov_o || so_o));

    p_cond_summary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rec_en_i) |=> (cond_o[0] == so_o));

    p_cond_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond_o[3:1]));

    p_carry_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !carry_en_i) |=> $stable({ca_o, ca32_o}));

    p_ovf_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ovf_en_i) |=> $stable({ov_o, ov32_o, so_o}));

    p_rec_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !rec_en_i) |=> $stable(cond_o));

endmodule

bind int_flag_unit int_flag_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .carry_en_i (carry_en_i),
    .ovf_en_i   (ovf_en_i),
    .rec_en_i   (rec_en_i),
    .own_mask_i (own_mask_i),
    .own_ca_i   (own_ca_i),
    .own_ca32_i (own_ca32_i),
    .ca_o       (ca_o),
    .ca32_o     (ca32_o),
    .ov_o       (ov_o),
    .ov32_o     (ov32_o),
    .so_o       (so_o),
    .cond_o     (cond_o)
);

// File: tb/int_flag_unit_tb_top.sv
`timescale 1ns/1ps
module int_flag_unit_tb_top;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic          inv_a_i = 1'b0;
    logic [DW-1:0] op_a_i = '0;
    logic [DW-1:0] op_b_i = '0;
    logic          b_vld_i = 1'b0;
    logic [DW-1:0] imm_i = '0;
    logic          imm_vld_i = 1'b0;
    logic [DW-1:0] result_i = '0;
    logic          carry_en_i = 1'b0;
    logic          ovf_en_i = 1'b0;
    logic          rec_en_i = 1'b0;
    logic [1:0]    own_mask_i = 2'b00;
    logic          own_ca_i = 1'b0;
    logic          own_ca32_i = 1'b0;
    logic          ca_o, ca32_o, ov_o, ov32_o, so_o;
    logic [3:0]    cond_o;

    always #2.5 clk = ~clk;

    int_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .inv_a_i(inv_a_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .b_vld_i(b_vld_i),
        .imm_i(imm_i), .imm_vld_i(imm_vld_i), .result_i(result_i),
        .carry_en_i(carry_en_i), .ovf_en_i(ovf_en_i), .rec_en_i(rec_en_i),
        .own_mask_i(own_mask_i), .own_ca_i(own_ca_i), .own_ca32_i(own_ca32_i),
        .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
        .so_o(so_o), .cond_o(cond_o)
    );

    // packed observation: {ca, ca32, ov, ov32, so, cond[3:0]}
    typedef struct {
        logic [8:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic mon_req = 1'b0;
    logic done = 1'b0;

    // reference state
    logic m_ca, m_ca32, m_ov, m_ov32, m_so;
    logic [3:0] m_cond;

    function automatic logic [8:0] model_obs();
        return {m_ca, m_ca32, m_ov, m_ov32, m_so, m_cond};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic compare(input logic [8:0] act, input logic [8:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per driven cycle
    always @(posedge clk) begin
        if (mon_req) begin
            #1;
            if (q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2: actual=result expected=none (empty scoreboard)");
            end else begin
                exp_t e;
                e = q.pop_front();
                compare({ca_o, ca32_o, ov_o, ov32_o, so_o, cond_o}, e.val, e.tag);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        valid_i = 1'b0;
        {m_ca, m_ca32, m_ov, m_ov32, m_so} = '0;
        m_cond = '0;
        repeat (2) @(negedge clk);
        compare({ca_o, ca32_o, ov_o, ov32_o, so_o, cond_o}, 9'h000, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // driver: applies one cycle of stimulus and queues the expected outcome
    task automatic drive(input string tag, input logic v, input logic inv,
                         input logic [DW-1:0] a, input logic [DW-1:0] b, input logic bv,
                         input logic [DW-1:0] im, input logic iv, input logic [DW-1:0] res,
                         input logic ce, input logic oe, input logic re,
                         input logic [1:0] mask, input logic oca, input logic oca32);
        logic [DW-1:0] ae, sec;
        logic c64, c32, o64, o32, neg, zer, pos;
        exp_t e;
        @(negedge clk);
        valid_i = v; inv_a_i = inv; op_a_i = a; op_b_i = b; b_vld_i = bv;
        imm_i = im; imm_vld_i = iv; result_i = res; carry_en_i = ce;
        ovf_en_i = oe; rec_en_i = re; own_mask_i = mask;
        own_ca_i = oca; own_ca32_i = oca32;

        ae  = inv ? ~a : a;
        c64 = (ae > res) || (bv && (b > res)) || (iv && (im > res));
        c32 = (ae[31:0] > res[31:0]) || (bv && (b[31:0] > res[31:0])) ||
              (iv && (im[31:0] > res[31:0]));
        sec = bv ? b : im;
        o64 = (ae[63] == sec[63]) && (res[63] != ae[63]);
        o32 = (ae[31] == sec[31]) && (res[31] != ae[31]);
        neg = res[63];
        zer = (res == '0);
        pos = !neg && !zer;
        if (v) begin
            if (ce) begin
                m_ca   = mask[0] ? oca   : c64;
                m_ca32 = mask[1] ? oca32 : c32;
            end
            if (oe && (bv || iv)) begin
                m_ov   = o64;
                m_ov32 = o32;
                m_so   = m_so | o64;
            end
            if (re) m_cond = {neg, pos, zer, m_so};
        end
        e.val = model_obs();
        e.tag = tag;
        q.push_back(e);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
        valid_i = 1'b0;
    endtask

    localparam logic [DW-1:0] ALL1 = '1;
    localparam logic [DW-1:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [DW-1:0] SMIN = 64'h8000_0000_0000_0000;

    initial begin
        do_reset();
        // carry, full and half width
        drive("R5 small add no carry", 1, 0, 64'd5, 64'd7, 1, 0, 0, 64'd12, 1, 0, 0, 2'b00, 0, 0);
        drive("R5 wrap sets carry", 1, 0, ALL1, 64'd1, 1, 0, 0, 64'd0, 1, 0, 0, 2'b00, 0, 0);
        drive("R6 half carry only", 1, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1, 0, 0,
              64'h0000_0001_0000_0000, 1, 0, 0, 2'b00, 0, 0);
        // inversion of operand A
        drive("R3 inverted A no carry", 1, 1, ALL1, 64'd0, 1, 0, 0, 64'd5, 1, 0, 0, 2'b00, 0, 0);
        drive("R3 plain A carries", 1, 0, ALL1, 64'd0, 1, 0, 0, 64'd5, 1, 0, 0, 2'b00, 0, 0);
        // immediate as operand
        drive("R4 imm below result", 1, 0, 64'd3, ALL1, 0, 64'h10, 1, 64'h13, 1, 0, 0, 2'b00, 0, 0);
        drive("R4 imm above result", 1, 0, 64'd3, 64'd0, 0, 64'h20, 1, 64'h10, 1, 0, 0, 2'b00, 0, 0);
        drive("R4 absent B ignored", 1, 0, 64'd1, ALL1, 0, 64'd0, 0, 64'd2, 1, 0, 0, 2'b00, 0, 0);
        // own carry mask
        drive("R7 mask bit0 own ca", 1, 0, ALL1, 64'd1, 1, 0, 0, 64'd0, 1, 0, 0, 2'b01, 0, 1);
        drive("R7 mask bit1 own ca32", 1, 0, 64'd1, 64'd1, 1, 0, 0, 64'd2, 1, 0, 0, 2'b10, 0, 1);
        drive("R7 mask ignored carry off", 1, 0, 64'd1, 64'd1, 1, 0, 0, 64'd2, 0, 0, 0, 2'b11, 1, 0);
        // overflow and summary
        drive("R8 full overflow", 1, 0, SMAX, 64'd1, 1, 0, 0, SMIN, 0, 1, 0, 2'b00, 0, 0);
        drive("R9 half overflow only", 1, 0, 64'h7FFF_FFFF, 64'd1, 1, 0, 0, 64'h8000_0000,
              0, 1, 0, 2'b00, 0, 0);
        drive("R10 summary stays set", 1, 0, 64'd1, 64'd1, 1, 0, 0, 64'd2, 0, 1, 0, 2'b00, 0, 0);
        drive("R8 imm as second operand", 1, 0, SMIN, 64'd0, 0, SMIN, 1, 64'd0, 0, 1, 0, 2'b00, 0, 0);
        drive("R8 single operand holds", 1, 0, SMAX, 64'd0, 0, 64'd0, 0, SMIN, 0, 1, 0, 2'b00, 0, 0);
        // hold while idle
        drive("R2 idle hold", 0, 1, ALL1, ALL1, 1, ALL1, 1, 64'd0, 1, 1, 1, 2'b11, 1, 1);
        // record
        drive("R11 negative record", 1, 0, 64'd0, 64'd0, 1, 0, 0, SMIN, 0, 0, 1, 2'b00, 0, 0);
        drive("R11 zero record", 1, 0, 64'd0, 64'd0, 1, 0, 0, 64'd0, 0, 0, 1, 2'b00, 0, 0);
        drive("R12 record only keeps carry", 1, 0, ALL1, ALL1, 1, 0, 0, 64'd9, 0, 0, 1, 2'b00, 0, 0);
        drive("R12 carry only keeps cond", 1, 0, ALL1, 64'd0, 1, 0, 0, 64'd0, 1, 0, 0, 2'b00, 0, 0);
        // fresh summary: record sees this operation's overflow
        do_reset();
        drive("R11 record sees new summary", 1, 0, SMAX, SMAX, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE,
              1, 1, 1, 2'b00, 0, 0);
        drive("R11 positive record", 1, 0, 64'd1, 64'd1, 1, 0, 0, 64'd2, 1, 1, 1, 2'b00, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

endmodule